// File: doc/BRIEF.md
# Bank Conflict Router

This block sits at the request entrance of one cache bank. It decides whether an incoming inner acquire or inner release may be handed to a transaction tracker, or whether it must wait because an acquire tracker already in flight covers the same set or the same block. Each acquire tracker reports its current phase and the block address it works on. The router compares both incoming addresses against every tracker in parallel. It raises a ready toward each requester only when no tracker blocks that request and a free tracker of the right kind exists.

The release test depends on the tracker's phase. While the tracker is still reading or waiting for metadata, any release to the same set is held off, because the tracker has not yet chosen a victim way. While the tracker waits to be granted the writeback unit, releases pass freely, so that a release can never be stuck behind a writeback that itself waits on a release. Once the writeback unit is granted, only a release to the exact same block is held off. An acquire is held off by any busy tracker in the same set.

Both request ports follow valid/ready rules. Ready never depends on valid, and a request transfers on a cycle where both are high. The requester must hold valid and the address stable until that cycle. An accepted request is issued one cycle later on a registered valid-only port, with a one-hot tracker select and the address. The select goes to the lowest-index free tracker. For that one cycle the router holds the chosen tracker as reserved, until the tracker's own phase can show it is busy.

Top module: `bank_conflict_router`

## Requirements
- R1: An acquire tracker in phase idle (encoding 0) that is not reserved raises neither its acquire match flag nor its release match flag.
- R2: A non-idle acquire tracker raises its acquire match flag when the incoming acquire address has the same set index as the tracker, whatever the tags. The set index is the low SET_W bits of the block address and the tag is the upper bits.
- R3: In phase metadata read (1) or metadata response (2), a tracker raises its release match flag when the release has the same set index, even when the tags differ. The full phase encoding is idle 0, metadata read 1, metadata response 2, writeback request 3, writeback response 4, inner probe 5, outer acquire 6, busy 7, metadata write 8.
- R4: In phase writeback request (3), a tracker never raises its release match flag, not even for an identical block address.
- R5: In phases 4 to 8, a tracker raises its release match flag only when the whole block address equals its own. The same set with a different tag does not match.
- R6: acq_ready is high exactly when no acquire match flag is set and at least one acquire tracker is idle and not reserved. rel_ready is high exactly when no release match flag is set and at least one release tracker is neither busy nor reserved. Neither ready depends on its valid.
- R7: When valid and ready are both high at a clock edge, the matching issue port shows valid, a one-hot select of the lowest-index free tracker, and the accepted address for the following cycle. The issue valid is low after an edge with no transfer.
- R8: In the cycle an acquire issue is shown, the selected tracker is treated as being in metadata read with the issued address: it is not free, and it matches same-set acquires and releases. In the cycle a release issue is shown, the selected release tracker is not free.
- R9: During reset and in the first cycle after it, both issue valids are low and no tracker is reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_valid | input | 1 | Incoming acquire request valid |
| acq_addr | input | ADDR_W | Block address of incoming acquire |
| acq_ready | output | 1 | Acquire may transfer this cycle |
| rel_valid | input | 1 | Incoming release request valid |
| rel_addr | input | ADDR_W | Block address of incoming release |
| rel_ready | output | 1 | Release may transfer this cycle |
| trk_phase | input | 4*N_ACQ | Phase of each acquire tracker, tracker i in bits [4i+3:4i] |
| trk_addr | input | ADDR_W*N_ACQ | Block address of each acquire tracker |
| rel_busy | input | N_REL | Busy flag of each release tracker |
| acq_hit | output | N_ACQ | Per-tracker acquire match flags |
| rel_hit | output | N_ACQ | Per-tracker release match flags |
| acq_issue_vld | output | 1 | Registered acquire handoff valid |
| acq_issue_sel | output | N_ACQ | One-hot selected acquire tracker |
| acq_issue_addr | output | ADDR_W | Address handed to the acquire tracker |
| rel_issue_vld | output | 1 | Registered release handoff valid |
| rel_issue_sel | output | N_REL | One-hot selected release tracker |
| rel_issue_addr | output | ADDR_W | Address handed to the release tracker |

## Verification
The bench builds the router with three acquire trackers, two release trackers, a 10-bit block address and 3 set bits. With three acquire trackers, a busy tracker 0 leaves a free tracker above it, so lowest-index selection past a busy slot is exercised. With two release trackers, a pending reservation combined with a busy flag can leave no release tracker free. The small set field makes it easy to choose addresses with the same set but different tags, which is the case that tells the three release-matching phases apart.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
  localparam int PHASE_W = 4;

  typedef enum logic [PHASE_W-1:0] {
    PH_IDLE      = 4'd0,
    PH_META_RD   = 4'd1,
    PH_META_RESP = 4'd2,
    PH_WB_REQ    = 4'd3,
    PH_WB_RESP   = 4'd4,
    PH_PROBE     = 4'd5,
    PH_OUTER     = 4'd6,
    PH_BUSY      = 4'd7,
    PH_META_WR   = 4'd8
  } phase_e;
endpackage

// File: rtl/rt_match_unit.sv
module rt_match_unit
  import bcr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SET_W  = 7
) (
  input  logic [PHASE_W-1:0] phase,
  input  logic [ADDR_W-1:0]  trk_addr,
  input  logic [ADDR_W-1:0]  acq_addr,
  input  logic [ADDR_W-1:0]  rel_addr,
  output logic               acq_hit,
  output logic               rel_hit
);
  logic acq_same_set;
  logic rel_same_set;
  logic rel_same_blk;

  always_comb begin
    acq_same_set = (acq_addr[SET_W-1:0] == trk_addr[SET_W-1:0]);
    rel_same_set = (rel_addr[SET_W-1:0] == trk_addr[SET_W-1:0]);
    rel_same_blk = (rel_addr == trk_addr);

    acq_hit = (phase != PH_IDLE) && acq_same_set;

    // Release rule depends on how far the tracker has progressed.
    case (phase)
      PH_IDLE:                 rel_hit = 1'b0;
      PH_META_RD, PH_META_RESP: rel_hit = rel_same_set;
      PH_WB_REQ:               rel_hit = 1'b0;
      default:                 rel_hit = rel_same_blk;
    endcase
  end
endmodule

// File: rtl/rt_pick_lowest.sv
module rt_pick_lowest #(
  parameter int N = 2
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  always_comb begin
    grant = '0;
    any   = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !any) begin
        grant[i] = 1'b1;
        any      = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rt_issue_reg.sv
module rt_issue_reg #(
  parameter int N      = 2,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [N-1:0]      sel_in,
  input  logic [ADDR_W-1:0] addr_in,
  output logic              vld,
  output logic [N-1:0]      sel,
  output logic [ADDR_W-1:0] addr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld  <= 1'b0;
      sel  <= '0;
      addr <= '0;
    end else begin
      vld <= fire;
      sel <= fire ? sel_in : '0;
      if (fire) addr <= addr_in;
    end
  end
endmodule

// File: rtl/bank_conflict_router.sv
module bank_conflict_router
  import bcr_pkg::*;
#(
  parameter int N_ACQ  = 2,
  parameter int N_REL  = 1,
  parameter int ADDR_W = 16,
  parameter int SET_W  = 7
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      acq_valid,
  input  logic [ADDR_W-1:0]         acq_addr,
  output logic                      acq_ready,
  input  logic                      rel_valid,
  input  logic [ADDR_W-1:0]         rel_addr,
  output logic                      rel_ready,
  input  logic [PHASE_W*N_ACQ-1:0]  trk_phase,
  input  logic [ADDR_W*N_ACQ-1:0]   trk_addr,
  input  logic [N_REL-1:0]          rel_busy,
  output logic [N_ACQ-1:0]          acq_hit,
  output logic [N_ACQ-1:0]          rel_hit,
  output logic                      acq_issue_vld,
  output logic [N_ACQ-1:0]          acq_issue_sel,
  output logic [ADDR_W-1:0]         acq_issue_addr,
  output logic                      rel_issue_vld,
  output logic [N_REL-1:0]          rel_issue_sel,
  output logic [ADDR_W-1:0]         rel_issue_addr
);
  localparam int TAG_W = ADDR_W - SET_W;

  logic [N_ACQ-1:0] acq_free;
  logic [N_ACQ-1:0] acq_grant;
  logic             acq_any;
  logic [N_REL-1:0] rel_free;
  logic [N_REL-1:0] rel_grant;
  logic             rel_any;
  logic             acq_fire;
  logic             rel_fire;

  // A tracker chosen on the previous edge counts as starting its metadata read.
  for (genvar i = 0; i < N_ACQ; i++) begin : g_trk
    logic [PHASE_W-1:0] eff_phase;
    logic [ADDR_W-1:0]  eff_addr;

    assign eff_phase = acq_issue_sel[i] ? PHASE_W'(PH_META_RD)
                                        : trk_phase[i*PHASE_W +: PHASE_W];
    assign eff_addr  = acq_issue_sel[i] ? acq_issue_addr
                                        : trk_addr[i*ADDR_W +: ADDR_W];
    assign acq_free[i] = (eff_phase == PHASE_W'(PH_IDLE));

    rt_match_unit #(.ADDR_W(ADDR_W), .SET_W(SET_W)) u_match (
      .phase    (eff_phase),
      .trk_addr (eff_addr),
      .acq_addr (acq_addr),
      .rel_addr (rel_addr),
      .acq_hit  (acq_hit[i]),
      .rel_hit  (rel_hit[i])
    );
  end

  assign rel_free = ~rel_busy & ~rel_issue_sel;

  rt_pick_lowest #(.N(N_ACQ)) u_acq_pick (
    .req(acq_free), .grant(acq_grant), .any(acq_any)
  );
  rt_pick_lowest #(.N(N_REL)) u_rel_pick (
    .req(rel_free), .grant(rel_grant), .any(rel_any)
  );

  assign acq_ready = (acq_hit == '0) && acq_any && (TAG_W > 0);
  assign rel_ready = (rel_hit == '0) && rel_any;
  assign acq_fire  = acq_valid && acq_ready;
  assign rel_fire  = rel_valid && rel_ready;

  rt_issue_reg #(.N(N_ACQ), .ADDR_W(ADDR_W)) u_acq_issue (
    .clk(clk), .rst_n(rst_n), .fire(acq_fire), .sel_in(acq_grant),
    .addr_in(acq_addr), .vld(acq_issue_vld), .sel(acq_issue_sel),
    .addr(acq_issue_addr)
  );
  rt_issue_reg #(.N(N_REL), .ADDR_W(ADDR_W)) u_rel_issue (
    .clk(clk), .rst_n(rst_n), .fire(rel_fire), .sel_in(rel_grant),
    .addr_in(rel_addr), .vld(rel_issue_vld), .sel(rel_issue_sel),
    .addr(rel_issue_addr)
  );
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker #(
  parameter int N_ACQ  = 2,
  parameter int N_REL  = 1,
  parameter int ADDR_W = 16,
  parameter int SET_W  = 7
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     acq_valid,
  input logic [ADDR_W-1:0]        acq_addr,
  input logic                     acq_ready,
  input logic                     rel_valid,
  input logic [ADDR_W-1:0]        rel_addr,
  input logic                     rel_ready,
  input logic [4*N_ACQ-1:0]       trk_phase,
  input logic [ADDR_W*N_ACQ-1:0]  trk_addr,
  input logic [N_ACQ-1:0]         acq_hit,
  input logic [N_ACQ-1:0]         rel_hit,
  input logic                     acq_issue_vld,
  input logic [N_ACQ-1:0]         acq_issue_sel,
  input logic [ADDR_W-1:0]        acq_issue_addr,
  input logic                     rel_issue_vld,
  input logic [N_REL-1:0]         rel_issue_sel,
  input logic [ADDR_W-1:0]        rel_issue_addr
);
  for (genvar i = 0; i < N_ACQ; i++) begin : g_chk
    logic [3:0]        ph;
    logic [ADDR_W-1:0] ta;
    assign ph = trk_phase[i*4 +: 4];
    assign ta = trk_addr[i*ADDR_W +: ADDR_W];

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == 4'd0 && !acq_issue_sel[i]) |-> (!acq_hit[i] && !rel_hit[i]));

    // R4
    wb_wait_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == 4'd3 && !acq_issue_sel[i]) |-> !rel_hit[i]);

    // R5
    late_exact_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph >= 4'd4 && ph <= 4'd8 && !acq_issue_sel[i] && rel_addr != ta)
        |-> !rel_hit[i]);
  end

  // R6
  acq_ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acq_ready |-> (acq_hit == '0));

  // R6
  rel_ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_ready |-> (rel_hit == '0));

  // R7
  acq_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_valid && acq_ready) |=> (acq_issue_vld && $countones(acq_issue_sel) == 1
                                  && acq_issue_addr == $past(acq_addr)));

  // R7
  rel_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_valid && rel_ready) |=> (rel_issue_vld && $countones(rel_issue_sel) == 1
                                  && rel_issue_addr == $past(rel_addr)));

  // R7
  rel_no_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rel_valid && rel_ready) |=> !rel_issue_vld);

  // R8
  reserve_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acq_issue_vld && acq_addr[SET_W-1:0] == acq_issue_addr[SET_W-1:0])
      |-> !acq_ready);
endmodule

bind bank_conflict_router bcr_checker #(
  .N_ACQ(N_ACQ), .N_REL(N_REL), .ADDR_W(ADDR_W), .SET_W(SET_W)
) u_bcr_chk (
  .clk(clk), .rst_n(rst_n),
  .acq_valid(acq_valid), .acq_addr(acq_addr), .acq_ready(acq_ready),
  .rel_valid(rel_valid), .rel_addr(rel_addr), .rel_ready(rel_ready),
  .trk_phase(trk_phase), .trk_addr(trk_addr),
  .acq_hit(acq_hit), .rel_hit(rel_hit),
  .acq_issue_vld(acq_issue_vld), .acq_issue_sel(acq_issue_sel),
  .acq_issue_addr(acq_issue_addr),
  .rel_issue_vld(rel_issue_vld), .rel_issue_sel(rel_issue_sel),
  .rel_issue_addr(rel_issue_addr)
);

// File: tb/tb_bank_conflict_router.sv
`timescale 1ns/1ps
module tb_bank_conflict_router;
  localparam int NA = 3;
  localparam int NR = 2;
  localparam int AW = 10;
  localparam int SW = 3;
  localparam int TW = AW - SW;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              acq_valid = 1'b0;
  logic [AW-1:0]     acq_addr = '0;
  logic              acq_ready;
  logic              rel_valid = 1'b0;
  logic [AW-1:0]     rel_addr = '0;
  logic              rel_ready;
  logic [4*NA-1:0]   trk_phase = '0;
  logic [AW*NA-1:0]  trk_addr = '0;
  logic [NR-1:0]     rel_busy = '0;
  logic [NA-1:0]     acq_hit;
  logic [NA-1:0]     rel_hit;
  logic              acq_issue_vld;
  logic [NA-1:0]     acq_issue_sel;
  logic [AW-1:0]     acq_issue_addr;
  logic              rel_issue_vld;
  logic [NR-1:0]     rel_issue_sel;
  logic [AW-1:0]     rel_issue_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  bank_conflict_router #(.N_ACQ(NA), .N_REL(NR), .ADDR_W(AW), .SET_W(SW)) dut (
    .clk(clk), .rst_n(rst_n),
    .acq_valid(acq_valid), .acq_addr(acq_addr), .acq_ready(acq_ready),
    .rel_valid(rel_valid), .rel_addr(rel_addr), .rel_ready(rel_ready),
    .trk_phase(trk_phase), .trk_addr(trk_addr), .rel_busy(rel_busy),
    .acq_hit(acq_hit), .rel_hit(rel_hit),
    .acq_issue_vld(acq_issue_vld), .acq_issue_sel(acq_issue_sel),
    .acq_issue_addr(acq_issue_addr),
    .rel_issue_vld(rel_issue_vld), .rel_issue_sel(rel_issue_sel),
    .rel_issue_addr(rel_issue_addr)
  );

  function automatic logic [AW-1:0] mk(input int tag, input int set);
    return {TW'(tag), SW'(set)};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  task automatic set_trk(input int i, input logic [3:0] ph, input logic [AW-1:0] a);
    trk_phase[i*4 +: 4] = ph;
    trk_addr[i*AW +: AW] = a;
  endtask

  task automatic all_idle();
    for (int i = 0; i < NA; i++) set_trk(i, 4'd0, '0);
    rel_busy = '0;
    acq_valid = 1'b0;
    rel_valid = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 acq issue in reset", acq_issue_vld, 0);
    chk("R9 rel issue in reset", rel_issue_vld, 0);
    rst_n = 1'b1;
    #1;
    chk("R9 no reservation", acq_issue_sel, 0);
    chk("R1 idle acq hits", acq_hit, 0);
    chk("R1 idle rel hits", rel_hit, 0);
    chk("R6 idle acq ready", acq_ready, 1);
    chk("R6 idle rel ready", rel_ready, 1);
  endtask

  task automatic t_acq_set();
    @(negedge clk);
    all_idle();
    set_trk(1, 4'd7, mk(5, 2));
    acq_addr = mk(9, 2);
    #1;
    chk("R2 same set other tag", acq_hit, 3'b010);
    chk("R6 acq blocked", acq_ready, 0);
    acq_addr = mk(9, 3);
    #1;
    chk("R2 other set", acq_hit, 0);
    chk("R6 acq open", acq_ready, 1);
  endtask

  task automatic t_rel_early();
    for (int p = 1; p <= 2; p++) begin
      @(negedge clk);
      all_idle();
      set_trk(0, 4'(p), mk(5, 2));
      rel_addr = mk(6, 2);
      #1;
      chk("R3 set match early", rel_hit, 3'b001);
      chk("R6 rel blocked early", rel_ready, 0);
      rel_addr = mk(6, 4);
      #1;
      chk("R3 other set early", rel_hit, 0);
    end
  endtask

  task automatic t_rel_wb();
    @(negedge clk);
    all_idle();
    set_trk(2, 4'd3, mk(5, 2));
    rel_addr = mk(5, 2);
    #1;
    chk("R4 exact block while awaiting wb", rel_hit, 0);
    chk("R4 rel ready while awaiting wb", rel_ready, 1);
    acq_addr = mk(1, 2);
    #1;
    chk("R2 wb wait still blocks acquire", acq_hit, 3'b100);
  endtask

  task automatic t_rel_late();
    for (int p = 4; p <= 8; p++) begin
      @(negedge clk);
      all_idle();
      set_trk(0, 4'(p), mk(5, 2));
      rel_addr = mk(6, 2);
      #1;
      chk("R5 same set other tag late", rel_hit, 0);
      rel_addr = mk(5, 2);
      #1;
      chk("R5 exact block late", rel_hit, 3'b001);
    end
  endtask

  task automatic t_alloc();
    @(negedge clk);
    all_idle();
    set_trk(0, 4'd7, mk(2, 7));
    rel_busy = 2'b01;
    acq_addr = mk(3, 5);
    rel_addr = mk(1, 1);
    acq_valid = 1'b1;
    rel_valid = 1'b1;
    #1;
    chk("R6 acq ready before transfer", acq_ready, 1);
    chk("R6 rel ready before transfer", rel_ready, 1);
    @(posedge clk);
    #1;
    chk("R7 acq issue vld", acq_issue_vld, 1);
    chk("R7 acq lowest free", acq_issue_sel, 3'b010);
    chk("R7 acq issue addr", acq_issue_addr, mk(3, 5));
    chk("R7 rel issue vld", rel_issue_vld, 1);
    chk("R7 rel lowest free", rel_issue_sel, 2'b10);
    chk("R7 rel issue addr", rel_issue_addr, mk(1, 1));
    @(negedge clk);
    acq_valid = 1'b0;
    rel_valid = 1'b0;
    acq_addr = mk(4, 5);
    rel_addr = mk(7, 5);
    #1;
    chk("R8 reserved acq match", acq_hit, 3'b010);
    chk("R8 reserved acq ready", acq_ready, 0);
    chk("R8 reserved rel match", rel_hit, 3'b010);
    chk("R8 rel tracker reserved", rel_ready, 0);
    @(posedge clk);
    #1;
    chk("R7 no transfer acq", acq_issue_vld, 0);
    chk("R7 no transfer rel", rel_issue_vld, 0);
    chk("R8 reservation ends", acq_hit, 0);
    chk("R8 rel free again", rel_ready, 1);
    @(negedge clk);
    all_idle();
    acq_addr = mk(6, 6);
    rel_addr = mk(6, 0);
    acq_valid = 1'b1;
    rel_valid = 1'b1;
    @(posedge clk);
    #1;
    chk("R7 acq index zero", acq_issue_sel, 3'b001);
    chk("R7 rel index zero", rel_issue_sel, 2'b01);
    @(negedge clk);
    acq_valid = 1'b0;
    rel_valid = 1'b0;
    @(posedge clk);
  endtask

  task automatic t_full();
    @(negedge clk);
    all_idle();
    for (int i = 0; i < NA; i++) set_trk(i, 4'd7, mk(8, i));
    rel_busy = 2'b11;
    acq_addr = mk(8, 6);
    rel_addr = mk(9, 6);
    #1;
    chk("R6 no acq match", acq_hit, 0);
    chk("R6 no idle acq tracker", acq_ready, 0);
    chk("R6 no free rel tracker", rel_ready, 0);
    rel_busy = 2'b10;
    #1;
    chk("R6 one rel tracker free", rel_ready, 1);
  endtask

  initial begin
    t_reset();
    t_acq_set();
    t_rel_early();
    t_rel_wb();
    t_rel_late();
    t_alloc();
    t_full();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule